// File: doc/BRIEF.md
# STM-1 Frame Alignment State Machine

This block watches a byte-aligned 155 Mbit/s frame stream for the 32-bit alignment word. That word is two A1 bytes (0xF6) followed by two A2 bytes (0x28). The block tracks where that word should recur, one frame period later, and builds two layers of alignment status on top.

The inner layer is the out-of-frame (OOF) flag. It clears when two clean words arrive exactly one frame apart. It sets after a run of errored words at the tracked boundary. The run length is five in SDH mode and four in SONET mode. While out of frame, the block keeps the last boundary it knew, and it moves that boundary to any clean word it sees elsewhere.

The outer layer is the loss-of-frame (LOF) flag. It sets when OOF has persisted for 24 consecutive frames. It clears after 24 consecutive frames that carry clean, correctly spaced words while OOF is clear. A one-cycle frame-start pulse marks each boundary byte. Each status change raises its own change pulse, and an interrupt line combines the change pulses through per-flag mask inputs.

Top module: `stm1_frame_align`

## Requirements
- R1: While reset is high and in the first cycle after it falls, oof_o and lof_o are 1, and frame_start_o, oof_chg_o, lof_chg_o and irq_o are 0.
- R2: The alignment word is the byte sequence 0xF6, 0xF6, 0x28, 0x28 carried in four consecutive bytes with byte_vld_i high. A match is recognised on the byte that carries the last 0x28. Cycles with byte_vld_i low neither shift the byte window nor advance the frame position, whatever their data.
- R3: While OOF, oof_o falls one clock after the second of two clean words whose final bytes are exactly FRAME_LEN valid bytes apart. A single clean word at the boundary does not clear it.
- R4: While OOF, a clean word that does not end on the tracked boundary moves the boundary to its final byte and counts as the first of the two clean words.
- R5: While in frame, clean words that do not end on the tracked boundary have no effect on any output.
- R6: While in frame, oof_o rises one clock after the Nth consecutive errored word at the tracked boundary. N is 5 with sonet_mode_i=0 and 4 with sonet_mode_i=1. A clean word at the boundary restarts the run.
- R7: On entering OOF the boundary is kept, so two clean words at the old boundary restore alignment.
- R8: frame_start_o is a one-cycle pulse, one clock after each byte that lands on the tracked boundary: either the boundary reached by counting, or a new boundary set as in R4.
- R9: lof_o rises after 24 consecutive counted boundaries at which OOF, updated for that byte, is 1. It rises in the same clock as the status update for the 24th.
- R10: lof_o falls after 24 consecutive counted boundaries each carrying a clean word with OOF, updated for that byte, equal to 0. Any other counted boundary restarts the run.
- R11: oof_chg_o and lof_chg_o pulse for one cycle in the first cycle the corresponding flag shows its new value. irq_o pulses in that same cycle if any changed flag has its mask input (oof_mask_i, lof_mask_i) at 0. A mask value of 1 suppresses that flag's contribution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_i | input | 1 | Synchronous active-high reset |
| byte_vld_i | input | 1 | Qualifies byte_i for this cycle |
| byte_i | input | 8 | Aligned stream byte |
| sonet_mode_i | input | 1 | 1 selects the 4-error OOF entry threshold, 0 selects 5 |
| oof_mask_i | input | 1 | 1 keeps OOF changes off irq_o |
| lof_mask_i | input | 1 | 1 keeps LOF changes off irq_o |
| frame_start_o | output | 1 | Pulse after each boundary byte |
| oof_o | output | 1 | Out-of-frame status |
| lof_o | output | 1 | Loss-of-frame status |
| oof_chg_o | output | 1 | Pulse on any OOF change |
| lof_chg_o | output | 1 | Pulse on any LOF change |
| irq_o | output | 1 | Pulse on any unmasked status change |

## Verification
The hardest state to reach from the ports is a boundary move while the block is in frame. The old boundary must first collect the exact run of errors for the selected mode, while clean words that would otherwise steal alignment keep arriving elsewhere. Only after that may a clean word move the boundary. The stimulus reaches this by shifting the word's offset inside a continuous stream of frames, so the old position sees filler and the new position carries clean words. LOF exit is also awkward, because it needs two dozen clean boundaries after a long outage. It is reached with a long run of garbage frames followed by a long clean run. Throughout, idle cycles whose data looks like framing bytes are scattered through the stream, including inside alignment words.

// File: rtl/stm1_fa_pkg.sv
package stm1_fa_pkg;
  localparam logic [7:0]  A1_BYTE    = 8'hF6;
  localparam logic [7:0]  A2_BYTE    = 8'h28;
  localparam logic [31:0] ALIGN_WORD = {A1_BYTE, A1_BYTE, A2_BYTE, A2_BYTE};
endpackage

// File: rtl/fa_pattern_det.sv
module fa_pattern_det #(
  parameter int BYTE_W    = 8,
  parameter int WIN_BYTES = 4,
  parameter logic [WIN_BYTES*BYTE_W-1:0] PATTERN = '0
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              match_o
);
  localparam int HIST_W = (WIN_BYTES - 1) * BYTE_W;

  logic [HIST_W-1:0] hist_q;

  assign match_o = vld_i && ({hist_q, byte_i} == PATTERN);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hist_q <= '0;
    end else if (vld_i) begin
      hist_q <= {hist_q[HIST_W-BYTE_W-1:0], byte_i};
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(vld_i) |-> $stable(hist_q));
endmodule

// File: rtl/fa_frame_ctr.sv
module fa_frame_ctr #(
  parameter int FRAME_LEN = 2430
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic vld_i,
  input  logic reanchor_i,
  output logic wrap_o,
  output logic bound_o
);
  localparam int CW = $clog2(FRAME_LEN);

  logic [CW-1:0] pos_q;

  assign wrap_o  = vld_i && (pos_q == CW'(FRAME_LEN - 1));
  assign bound_o = wrap_o || reanchor_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pos_q <= '0;
    end else if (vld_i) begin
      pos_q <= bound_o ? '0 : pos_q + CW'(1);
    end
  end

  // R8
  pos_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    pos_q < FRAME_LEN);

  // R4
  no_double_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(reanchor_i && wrap_o));
endmodule

// File: rtl/fa_oof_fsm.sv
module fa_oof_fsm #(
  parameter int GOOD_NEED = 2,
  parameter int ERR_SDH   = 5,
  parameter int ERR_SONET = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic vld_i,
  input  logic wrap_i,
  input  logic match_i,
  input  logic sonet_i,
  output logic reanchor_o,
  output logic oof_o,
  output logic oof_n_o
);
  localparam int ERR_MAX = (ERR_SDH > ERR_SONET) ? ERR_SDH : ERR_SONET;
  localparam int EW      = $clog2(ERR_MAX + 1);
  localparam int GW      = $clog2(GOOD_NEED + 1);

  logic          oof_q, oof_d;
  logic [GW-1:0] good_q, good_d;
  logic [EW-1:0] err_q, err_d, thr;

  assign thr = sonet_i ? EW'(ERR_SONET) : EW'(ERR_SDH);

  always_comb begin
    oof_d      = oof_q;
    good_d     = good_q;
    err_d      = err_q;
    reanchor_o = 1'b0;
    if (oof_q) begin
      if (wrap_i && match_i) begin
        if (good_q + GW'(1) >= GW'(GOOD_NEED)) begin
          oof_d  = 1'b0;
          good_d = '0;
          err_d  = '0;
        end else begin
          good_d = good_q + GW'(1);
        end
      end else if (wrap_i) begin
        good_d = '0;
      end else if (vld_i && match_i) begin
        reanchor_o = 1'b1;
        good_d     = GW'(1);
      end
    end else if (wrap_i) begin
      if (match_i) begin
        err_d = '0;
      end else if (err_q + EW'(1) >= thr) begin
        oof_d  = 1'b1;
        err_d  = '0;
        good_d = '0;
      end else begin
        err_d = err_q + EW'(1);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      oof_q  <= 1'b1;
      good_q <= '0;
      err_q  <= '0;
    end else begin
      oof_q  <= oof_d;
      good_q <= good_d;
      err_q  <= err_d;
    end
  end

  assign oof_o   = oof_q;
  assign oof_n_o = oof_d;

  // R3
  oof_exit_at_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(oof_q) |-> $past(wrap_i && match_i));

  // R6
  oof_entry_at_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(oof_q) |-> $past(wrap_i && !match_i));

  // R6
  err_run_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    err_q < ERR_MAX);

  // R7
  good_idle_in_sync_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !oof_q |-> (good_q == '0));
endmodule

// File: rtl/fa_lof_fsm.sv
module fa_lof_fsm #(
  parameter int LOF_SET = 24,
  parameter int LOF_CLR = 24
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic wrap_i,
  input  logic match_i,
  input  logic oof_n_i,
  output logic lof_o,
  output logic lof_n_o
);
  localparam int LMAX = (LOF_SET > LOF_CLR) ? LOF_SET : LOF_CLR;
  localparam int LW   = $clog2(LMAX + 1);

  logic          lof_q, lof_d;
  logic [LW-1:0] run_q, run_d;

  always_comb begin
    lof_d = lof_q;
    run_d = run_q;
    if (wrap_i) begin
      if (!lof_q) begin
        if (oof_n_i) begin
          if (run_q + LW'(1) >= LW'(LOF_SET)) begin
            lof_d = 1'b1;
            run_d = '0;
          end else begin
            run_d = run_q + LW'(1);
          end
        end else begin
          run_d = '0;
        end
      end else begin
        if (!oof_n_i && match_i) begin
          if (run_q + LW'(1) >= LW'(LOF_CLR)) begin
            lof_d = 1'b0;
            run_d = '0;
          end else begin
            run_d = run_q + LW'(1);
          end
        end else begin
          run_d = '0;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      lof_q <= 1'b1;
      run_q <= '0;
    end else begin
      lof_q <= lof_d;
      run_q <= run_d;
    end
  end

  assign lof_o   = lof_q;
  assign lof_n_o = lof_d;

  // R9
  lof_run_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    run_q < LMAX);

  // R10
  lof_move_at_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (lof_q != $past(lof_q)) |-> $past(wrap_i));
endmodule

// File: rtl/stm1_frame_align.sv
module stm1_frame_align
  import stm1_fa_pkg::*;
#(
  parameter int FRAME_LEN = 2430,
  parameter int GOOD_NEED = 2,
  parameter int ERR_SDH   = 5,
  parameter int ERR_SONET = 4,
  parameter int LOF_SET   = 24,
  parameter int LOF_CLR   = 24
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic       sonet_mode_i,
  input  logic       oof_mask_i,
  input  logic       lof_mask_i,
  output logic       frame_start_o,
  output logic       oof_o,
  output logic       lof_o,
  output logic       oof_chg_o,
  output logic       lof_chg_o,
  output logic       irq_o
);
  logic match, wrap, bound, reanchor;
  logic oof_q, oof_n, lof_q, lof_n;
  logic fs_q, och_q, lch_q, irq_q;

  fa_pattern_det #(
    .BYTE_W(8), .WIN_BYTES(4), .PATTERN(ALIGN_WORD)
  ) det_i (
    .clk_i(clk_i), .rst_i(rst_i), .vld_i(byte_vld_i), .byte_i(byte_i),
    .match_o(match)
  );

  fa_frame_ctr #(.FRAME_LEN(FRAME_LEN)) ctr_i (
    .clk_i(clk_i), .rst_i(rst_i), .vld_i(byte_vld_i),
    .reanchor_i(reanchor), .wrap_o(wrap), .bound_o(bound)
  );

  fa_oof_fsm #(
    .GOOD_NEED(GOOD_NEED), .ERR_SDH(ERR_SDH), .ERR_SONET(ERR_SONET)
  ) oof_i (
    .clk_i(clk_i), .rst_i(rst_i), .vld_i(byte_vld_i), .wrap_i(wrap),
    .match_i(match), .sonet_i(sonet_mode_i), .reanchor_o(reanchor),
    .oof_o(oof_q), .oof_n_o(oof_n)
  );

  fa_lof_fsm #(.LOF_SET(LOF_SET), .LOF_CLR(LOF_CLR)) lof_i (
    .clk_i(clk_i), .rst_i(rst_i), .wrap_i(wrap), .match_i(match),
    .oof_n_i(oof_n), .lof_o(lof_q), .lof_n_o(lof_n)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      fs_q  <= 1'b0;
      och_q <= 1'b0;
      lch_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      fs_q  <= bound;
      och_q <= oof_n != oof_q;
      lch_q <= lof_n != lof_q;
      irq_q <= ((oof_n != oof_q) && !oof_mask_i) ||
               ((lof_n != lof_q) && !lof_mask_i);
    end
  end

  assign frame_start_o = fs_q;
  assign oof_o         = oof_q;
  assign lof_o         = lof_q;
  assign oof_chg_o     = och_q;
  assign lof_chg_o     = lch_q;
  assign irq_o         = irq_q;

  // R9
  lof_set_needs_oof_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(lof_o) |-> oof_o);

  // R10
  lof_clear_needs_sync_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(lof_o) |-> !oof_o);

  // R11
  oof_chg_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    oof_chg_o |-> (oof_o != $past(oof_o)));

  // R11
  irq_has_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |-> (oof_chg_o || lof_chg_o));
endmodule

// File: tb/stm1_frame_align_tb.sv
module stm1_frame_align_tb_top;
  localparam int L = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vld = 1'b0;
  logic [7:0] bdat = 8'h00;
  logic sonet = 1'b0, omask = 1'b0, lmask = 1'b0;
  logic fs, oof, lof, och, lch, irq;

  int n_tests = 0, n_fail = 0, gap_ctr = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  // model state
  logic [7:0] m_win[$];
  int m_idx = 0, m_good = 0, m_err = 0, m_run = 0;
  bit m_oof = 1, m_lof = 1;
  bit e_fs = 0, e_oof = 1, e_lof = 1, e_och = 0, e_lch = 0, e_irq = 0;

  always #5 clk = ~clk;

  stm1_frame_align #(.FRAME_LEN(L)) dut_i (
    .clk_i(clk), .rst_i(rst), .byte_vld_i(vld), .byte_i(bdat),
    .sonet_mode_i(sonet), .oof_mask_i(omask), .lof_mask_i(lmask),
    .frame_start_o(fs), .oof_o(oof), .lof_o(lof),
    .oof_chg_o(och), .lof_chg_o(lch), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input bit v, input logic [7:0] b);
    bit match, wrap, re, po, pl;
    e_fs = 0; e_och = 0; e_lch = 0; e_irq = 0;
    if (v) begin
      po = m_oof; pl = m_lof; re = 0;
      m_win.push_back(b);
      if (m_win.size() > 4) void'(m_win.pop_front());
      match = (m_win.size() == 4) && m_win[0] == 8'hF6 && m_win[1] == 8'hF6 &&
              m_win[2] == 8'h28 && m_win[3] == 8'h28;
      wrap = (m_idx == L - 1);
      if (m_oof) begin
        if (wrap && match) begin
          m_good++;
          if (m_good >= 2) begin m_oof = 0; m_good = 0; m_err = 0; end
        end else if (wrap) m_good = 0;
        else if (match) begin re = 1; m_good = 1; end
      end else if (wrap) begin
        if (match) m_err = 0;
        else begin
          m_err++;
          if (m_err >= (sonet ? 4 : 5)) begin m_oof = 1; m_err = 0; m_good = 0; end
        end
      end
      m_idx = (wrap || re) ? 0 : m_idx + 1;
      e_fs = wrap || re;
      if (wrap) begin
        if (!m_lof) begin
          if (m_oof) begin m_run++; if (m_run >= 24) begin m_lof = 1; m_run = 0; end end
          else m_run = 0;
        end else begin
          if (!m_oof && match) begin m_run++; if (m_run >= 24) begin m_lof = 0; m_run = 0; end end
          else m_run = 0;
        end
      end
      e_och = (m_oof != po);
      e_lch = (m_lof != pl);
      e_irq = (e_och && !omask) || (e_lch && !lmask);
    end
    e_oof = m_oof; e_lof = m_lof;
  endtask

  task automatic step(input bit v, input logic [7:0] b);
    @(negedge clk);
    chk("R8 frame_start", fs, e_fs);
    chk("R6 oof", oof, e_oof);
    chk("R9 lof", lof, e_lof);
    chk("R11 oof_chg", och, e_och);
    chk("R11 lof_chg", lch, e_lch);
    chk("R11 irq", irq, e_irq);
    vld = v; bdat = b;
    model(v, b);
  endtask

  function automatic logic [7:0] filler();
    logic [7:0] f;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    f = lfsr[7:0];
    if (f == 8'hF6 || f == 8'h28) f = f ^ 8'h80;
    return f;
  endfunction

  task automatic push(input logic [7:0] b);
    step(1, b);
    gap_ctr++;
    if (gap_ctr % 7 == 0) step(0, 8'hF6); // R2: idle data looks like A1
  endtask

  task automatic frames(input int n, input int off, input bit good, input bit extra);
    for (int k = 0; k < n; k++) begin
      for (int p = 0; p < L; p++) begin
        logic [7:0] b;
        b = filler();
        if (p >= off && p < off + 4) b = (p - off < 2) ? 8'hF6 : 8'h28;
        if (!good && p == off + 2) b = 8'h00;
        if (extra && p >= off + L/2 && p < off + L/2 + 4)
          b = (p - off - L/2 < 2) ? 8'hF6 : 8'h28;
        push(b);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 oof in reset", oof, 1); chk("R1 lof in reset", lof, 1);
    chk("R1 irq in reset", irq, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 oof", oof, 1); chk("R1 lof", lof, 1); chk("R1 frame_start", fs, 0);
    chk("R1 chg", {och, lch}, 0);
    // lock with gapped stream
    frames(3, 10, 1, 0);
    chk("R3 locked", oof, 0); chk("R2 gaps ignored", oof, 0); chk("R10 lof held", lof, 1);
    frames(17, 10, 1, 0);
    chk("R10 lof before 24", lof, 1);
    frames(8, 10, 1, 0);
    chk("R10 lof cleared", lof, 0);
    frames(2, 10, 1, 1);
    chk("R5 extra word ignored", oof, 0);
    // SDH threshold
    frames(4, 10, 0, 0); chk("R6 four errors sdh", oof, 0);
    frames(1, 10, 1, 0);
    frames(4, 10, 0, 0); chk("R6 run restarted", oof, 0);
    frames(1, 10, 0, 0); chk("R6 five errors sdh", oof, 1);
    frames(1, 10, 1, 0); chk("R3 one clean not enough", oof, 1);
    frames(1, 10, 1, 0); chk("R7 old boundary kept", oof, 0);
    // SONET threshold
    sonet = 1'b1;
    frames(3, 10, 0, 0); chk("R6 three errors sonet", oof, 0);
    frames(1, 10, 0, 0); chk("R6 four errors sonet", oof, 1);
    frames(2, 10, 1, 0); chk("R3 relock", oof, 0);
    sonet = 1'b0;
    // boundary move
    frames(4, 30, 1, 0); chk("R5 moved word ignored in frame", oof, 0);
    frames(1, 30, 1, 0); chk("R4 oof after move", oof, 1);
    frames(1, 30, 1, 0); chk("R4 relock at new boundary", oof, 0);
    chk("R9 lof stays clear", lof, 0);
    // long outage
    omask = 1'b1;
    frames(20, 30, 0, 0); chk("R9 lof before 24", lof, 0); chk("R6 oof outage", oof, 1);
    frames(10, 30, 0, 0); chk("R9 lof set", lof, 1);
    omask = 1'b0; lmask = 1'b1;
    frames(2, 30, 1, 0); chk("R3 relock after outage", oof, 0);
    frames(20, 30, 1, 0); chk("R10 lof held", lof, 1);
    frames(5, 30, 1, 0); chk("R10 lof clear", lof, 0);
    step(0, 8'h00); step(0, 8'h00);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule